// File: doc/BRIEF.md
# Coprocessor Operand Transfer Sequencer

This block carries one operand word between system memory and a numeric coprocessor whenever the coprocessor raises its transfer request. The request arrives asynchronously, so it first crosses a synchronizer. Once it is seen, the block issues two back-to-back bus operations on a simple request/done interface. The first operation reads the word and the second writes it. One of the two always addresses memory at the operand address. The other always addresses a fixed coprocessor I/O port. Which of them comes first depends on the direction flag.

During the status cycle of the first operation the block drives a one-cycle acknowledge. The coprocessor can use it to withdraw its request before the sequence ends. If the synchronized request is still high when the second operation completes, a fresh two-operation sequence follows at once. Extra wait cycles in either operation give the coprocessor more time to drop its request. The word read in the first operation is held in a register and driven as write data for the second.

Top module: `copxfer_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `busReq` and `xferAck` are low.
- R2: From idle, `busReq` first goes high on the third rising clock edge after `xferReq` goes high (two synchronizer stages, then one sequencer step).
- R3: With `toCop`=1 (memory to coprocessor), the first operation is a memory read (`busWrite`=0, `busIsIo`=0) at the operand address. The second is an I/O write (`busWrite`=1, `busIsIo`=1) to port `COP_PORT` (default 0x00FA).
- R4: With `toCop`=0 (coprocessor to memory), the first operation is an I/O read at `COP_PORT` and the second is a memory write at the operand address.
- R5: `xferAck` is high for exactly one cycle per sequence: the first cycle (status cycle) of the first operation. It is low in every other cycle.
- R6: Each operation starts with one status cycle and then holds `busReq` and its type and address stable until `busDone` is seen in a later cycle. A `busDone` during the status cycle is ignored.
- R7: `busRdata` is captured in the cycle that `busDone` ends the first operation. That word is driven on `busWdata` for the whole second operation. `busRdata` in other cycles has no effect.
- R8: `toCop` and `operandAddr` are sampled only on the edge that starts a sequence. Changes to them during a sequence have no effect on that sequence.
- R9: When the second operation completes and the synchronized request is low, `busReq` is low in the next cycle. If it is high, the next cycle is the status cycle of a new sequence with `xferAck` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xferReq | input | 1 | Asynchronous transfer request from the coprocessor |
| toCop | input | 1 | Direction: 1 = memory to coprocessor, 0 = coprocessor to memory |
| operandAddr | input | ADDR_W | Memory address of the operand |
| busDone | input | 1 | Bus operation completes this cycle |
| busRdata | input | DATA_W | Read data, valid with busDone |
| busReq | output | 1 | Bus operation requested |
| busWrite | output | 1 | Operation is a write |
| busIsIo | output | 1 | Operation targets I/O space |
| busAddr | output | ADDR_W | Operation address |
| busWdata | output | DATA_W | Write data |
| xferAck | output | 1 | One-cycle acknowledge in the first operation's status cycle |

## Verification
The completion of the second operation and the restart decision taken from the synchronized request fall in the same cycle. The bench drops `xferReq` at a random point in each sequence, sometimes only one or two edges before completion while the synchronizer still shows it high. It judges restart against a two-stage model of the request derived from R2. A `busDone` pulse landing on a status cycle also coincides with the start of an operation. The bench raises it randomly there and checks that the operation still waits for a later completion.

// File: rtl/cxs_pkg.sv
package cxs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_A_STAT,
    ST_A_CMD,
    ST_B_STAT,
    ST_B_CMD
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCtx;   // sample direction and operand address
    logic latchData;  // capture first-operation read data
    logic secondOp;   // second operation in progress
    logic active;     // any operation in progress
  } seqStrobe_t;

endpackage

// File: rtl/cxs_ctrl.sv
module cxs_ctrl
  import cxs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       xferReq,
  input  logic       busDone,
  output seqStrobe_t strb,
  output logic       busReq,
  output logic       xferAck
);

  localparam int SyncTop = SYNC_STAGES - 1;

  logic [SyncTop:0] syncQ;
  logic             reqSync;
  seqState_t        stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SyncTop-1:0], xferReq};
  end

  assign reqSync = syncQ[SyncTop];

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (reqSync) stateD = ST_A_STAT;
      ST_A_STAT: stateD = ST_A_CMD;
      ST_A_CMD:  if (busDone) stateD = ST_B_STAT;
      ST_B_STAT: stateD = ST_B_CMD;
      ST_B_CMD:  if (busDone) stateD = reqSync ? ST_A_STAT : ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.latchCtx  = (stateD == ST_A_STAT) && (stateQ != ST_A_STAT);
    strb.latchData = (stateQ == ST_A_CMD) && busDone;
    strb.secondOp  = (stateQ == ST_B_STAT) || (stateQ == ST_B_CMD);
    strb.active    = (stateQ != ST_IDLE);
  end

  assign busReq  = strb.active;
  assign xferAck = (stateQ == ST_A_STAT);

endmodule

// File: rtl/cxs_data.sv
module cxs_data
  import cxs_pkg::*;
#(
  parameter int              ADDR_W   = 24,
  parameter int              DATA_W   = 16,
  parameter logic [ADDR_W-1:0] COP_PORT = 'h00FA
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              toCop,
  input  logic [ADDR_W-1:0] operandAddr,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic              busIsIo,
  output logic [DATA_W-1:0] busWdata
);

  logic              dirQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              memOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= 1'b0;
      addrQ <= '0;
    end else if (strb.latchCtx) begin
      dirQ  <= toCop;
      addrQ <= operandAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataQ <= '0;
    else if (strb.latchData) dataQ <= busRdata;
  end

  // memory side first when moving toward the coprocessor, second otherwise
  assign memOp = dirQ ^ strb.secondOp;

  always_comb begin
    busWrite = strb.active & strb.secondOp;
    busIsIo  = strb.active & ~memOp;
    if (!strb.active) busAddr = '0;
    else if (memOp)   busAddr = addrQ;
    else              busAddr = COP_PORT;
  end

  assign busWdata = dataQ;

endmodule

// File: rtl/copxfer_seq.sv
module copxfer_seq
  import cxs_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter int                DATA_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] COP_PORT    = 'h00FA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferReq,
  input  logic              toCop,
  input  logic [ADDR_W-1:0] operandAddr,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busReq,
  output logic              busWrite,
  output logic              busIsIo,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              xferAck
);

  seqStrobe_t strb;

  cxs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .xferReq (xferReq),
    .busDone (busDone),
    .strb    (strb),
    .busReq  (busReq),
    .xferAck (xferAck)
  );

  cxs_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COP_PORT(COP_PORT)) data_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .toCop       (toCop),
    .operandAddr (operandAddr),
    .busRdata    (busRdata),
    .busAddr     (busAddr),
    .busWrite    (busWrite),
    .busIsIo     (busIsIo),
    .busWdata    (busWdata)
  );

endmodule

// File: rtl/copxfer_seq_chk.sv
module copxfer_seq_chk #(
  parameter int                ADDR_W   = 24,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] COP_PORT = 'h00FA
) (
  input logic              clk,
  input logic              rstN,
  input logic              busDone,
  input logic              busReq,
  input logic              busWrite,
  input logic              busIsIo,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              xferAck
);

  p_ack_in_op_r5: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> busReq);

  p_ack_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |=> !xferAck);

  p_start_has_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> xferAck);

  p_hold_until_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |=> (busReq && $stable(busAddr) && $stable(busWrite) && $stable(busIsIo)));

  p_fixed_port_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busIsIo) |-> (busAddr == COP_PORT));

  p_first_is_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> !busWrite);

  p_wdata_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && $past(busReq && busWrite)) |-> $stable(busWdata));

endmodule

bind copxfer_seq copxfer_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COP_PORT(COP_PORT)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busDone  (busDone),
  .busReq   (busReq),
  .busWrite (busWrite),
  .busIsIo  (busIsIo),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .xferAck  (xferAck)
);

// File: tb/copxfer_seq_tb_top.sv
module copxfer_seq_tb_top;

  localparam int          AW   = 24;
  localparam int          DW   = 16;
  localparam logic [23:0] PORT = 24'h0000FA;

  logic          clk = 1'b0;
  logic          rstN;
  logic          xferReq;
  logic          toCop;
  logic [AW-1:0] operandAddr;
  logic          busDone;
  logic [DW-1:0] busRdata;
  logic          busReq, busWrite, busIsIo, xferAck;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;

  int nChecks = 0;
  int nFails  = 0;

  logic          expDir;
  logic [AW-1:0] expAddr;
  int            dropCnt;
  logic          s1m, s2m;   // two-stage request model from R2

  always #10 clk = ~clk;

  copxfer_seq dut_i (
    .clk(clk), .rstN(rstN), .xferReq(xferReq), .toCop(toCop),
    .operandAddr(operandAddr), .busDone(busDone), .busRdata(busRdata),
    .busReq(busReq), .busWrite(busWrite), .busIsIo(busIsIo),
    .busAddr(busAddr), .busWdata(busWdata), .xferAck(xferAck)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin s1m <= 1'b0; s2m <= 1'b0; end
    else begin s1m <= xferReq; s2m <= s1m; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] opAddr(input logic second);
    return (expDir ^ second) ? expAddr : PORT;
  endfunction

  function automatic logic opIo(input logic second);
    return ~(expDir ^ second);
  endfunction

  task automatic checkOp(input logic second, input string tagA);
    chk({tagA, " busReq"}, busReq, 1'b1);
    chk({tagA, " busWrite"}, busWrite, second);
    chk({tagA, " busIsIo"}, busIsIo, opIo(second));
    chk({tagA, " busAddr R8"}, busAddr, opAddr(second));
  endtask

  task automatic scramble();
    toCop       = 1'($urandom);
    operandAddr = AW'($urandom);
  endtask

  task automatic maybeDrop();
    if (dropCnt == 0) xferReq = 1'b0;
    else dropCnt--;
  endtask

  // entered at the negedge of the first operation's status cycle
  task automatic runSeq(output logic restart);
    logic [DW-1:0] word;
    int            waits;
    string         dirTag;
    dirTag = expDir ? "R3" : "R4";
    word   = DW'($urandom);
    checkOp(1'b0, dirTag);
    chk("R5 ack in status", xferAck, 1'b1);
    busDone = 1'($urandom);   // R6: ignored in status cycle
    busRdata = DW'($urandom);
    scramble(); maybeDrop();
    tick();
    waits = $urandom % 4;
    for (int i = 0; i <= waits; i++) begin
      checkOp(1'b0, "R6 op1 hold");
      chk("R5 ack low op1 cmd", xferAck, 1'b0);
      busDone  = (i == waits);
      busRdata = (i == waits) ? word : DW'($urandom);
      scramble(); maybeDrop();
      tick();
    end
    checkOp(1'b1, dirTag);
    chk("R5 ack low op2", xferAck, 1'b0);
    chk("R7 wdata", busWdata, word);
    busDone  = 1'($urandom);  // R6: ignored in status cycle
    busRdata = DW'($urandom);
    scramble(); maybeDrop();
    tick();
    waits = $urandom % 4;
    restart = 1'b0;
    for (int i = 0; i <= waits; i++) begin
      checkOp(1'b1, "R6 op2 hold");
      chk("R7 wdata hold", busWdata, word);
      chk("R5 ack low op2 cmd", xferAck, 1'b0);
      busDone  = (i == waits);
      busRdata = DW'($urandom);
      scramble(); maybeDrop();
      if (i == waits) begin
        restart = s2m;
        expDir  = toCop;
        expAddr = operandAddr;
      end
      tick();
    end
    busDone = 1'b0;
    if (restart) begin
      chk("R9 restart ack", xferAck, 1'b1);
    end else begin
      chk("R9 idle busReq", busReq, 1'b0);
      chk("R9 idle ack", xferAck, 1'b0);
    end
  endtask

  task automatic transfer(input logic dir, input logic [AW-1:0] addr, input int drop);
    logic restart;
    int   guard;
    toCop = dir; operandAddr = addr; expDir = dir; expAddr = addr;
    dropCnt = drop;
    xferReq = 1'b1;
    tick();
    chk("R2 not yet 1", busReq, 1'b0);
    tick();
    chk("R2 not yet 2", busReq, 1'b0);
    tick();
    chk("R2 start edge 3", busReq, 1'b1);
    guard = 0;
    do begin
      runSeq(restart);
      if (restart) dropCnt = $urandom % 12;
      guard++;
    end while (restart && guard < 20);
    xferReq = 1'b0;
    while (busReq) begin
      // sequence that restarted after guard expiry: finish it
      runSeq(restart);
    end
    for (int i = 0; i < 3; i++) begin
      scramble();
      tick();
      chk("R9 stays idle", busReq, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; xferReq = 1'b0; toCop = 1'b0; operandAddr = '0;
    busDone = 1'b0; busRdata = '0;
    @(negedge clk);
    chk("R1 reset busReq", busReq, 1'b0);
    chk("R1 reset ack", xferAck, 1'b0);
    tick(); tick();
    rstN = 1'b1;
    tick();
    chk("R1 after reset busReq", busReq, 1'b0);
    chk("R1 after reset ack", xferAck, 1'b0);
    for (int i = 0; i < 4; i++) begin
      busDone = 1'($urandom); scramble();
      tick();
      chk("R9 no request idle", busReq, 1'b0);
    end
    busDone = 1'b0;
    // directed: both directions, early withdrawal, held request
    transfer(1'b1, 24'h123456, 1);
    transfer(1'b0, 24'hABCDEF, 0);
    transfer(1'b1, 24'hFFFFFF, 40);
    transfer(1'b0, 24'h0000FA, 3);
    for (int n = 0; n < 300; n++)
      transfer(1'($urandom), AW'($urandom), $urandom % 12);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule